// File: doc/BRIEF.md
# PC-Indexed Stride Prefetcher

This block watches the load stream. Each load is tagged with the program counter (PC) of the instruction that issued it. A small direct-mapped table, indexed by the low PC bits and tagged by the rest, keeps the last address, the last stride and a 2-bit confidence count for each load. When an access repeats the stored nonzero stride and confidence reaches the firing level, the block asks memory for the address a fixed number of strides ahead of the current access. A single request register with a valid/ready handshake carries that address.

Returning data lands in a small fully-associative prefetch buffer that sits beside the main cache. Demand lookups probe the buffer in the same cycle. A hit returns the word and frees the slot, so a prefetch that turns out wrong never displaces a cache line. The block does not issue a prefetch whose address is already in the buffer or already waiting in the request register.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset, `req_valid_o` is 0 and every lookup misses (`lk_hit_o` = 0).
- R2: Table index is `obs_pc_i[IDX_W-1:0]` and the tag is the remaining upper PC bits. A tag miss (or an empty entry) allocates the entry with stride 0 and confidence 0, which discards whatever that index held. The new PC must then retrain from scratch.
- R3: Stride is `addr - last_addr` in ADDR_W-bit two's complement. A matching stride raises confidence, saturating at 3. A prefetch fires only when the stride matches, the stride is nonzero, and the updated confidence is at least 2. With a fresh entry and a constant stride, the first request therefore follows the fourth access. Its address is `obs_addr_i + DIST*stride`, and `req_valid_o` rises on the clock edge that samples the access.
- R4: A stride mismatch lowers confidence by 1 and keeps the stored stride. If confidence is already 0, the new delta replaces the stored stride instead. The mismatching access never fires.
- R5: An access whose delta is zero never produces a request, however many times it repeats.
- R6: While `req_valid_o` is 1 and `req_ready_i` is 0, `req_addr_o` holds its value. A candidate arriving then is dropped. When `req_ready_i` is 1, the register may take a new candidate in the same cycle or otherwise clears.
- R7: A candidate is dropped if its address is valid in the buffer or equals the address waiting in the request register.
- R8: A lookup (`lk_valid_i` = 1) that matches a valid buffer slot sets `lk_hit_o` combinationally, returns that slot's data on `lk_data_o`, and invalidates the slot at the clock edge.
- R9: A fill whose address already sits in the buffer rewrites that slot's data in place. Any other fill writes the slot under a rotating pointer (slot 0, 1, …, BUF_DEPTH-1, 0), replacing whatever is there. A filled address always stays resident after its fill edge.
- R10: With `lk_valid_i` = 0, `lk_hit_o` is 0 and no slot is invalidated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| obs_valid_i | input | 1 | A load is observed this cycle |
| obs_pc_i | input | PC_W | PC of the observed load |
| obs_addr_i | input | ADDR_W | Address of the observed load |
| req_valid_o | output | 1 | Prefetch request pending |
| req_addr_o | output | ADDR_W | Prefetch address |
| req_ready_i | input | 1 | Memory accepts the request this cycle |
| fill_valid_i | input | 1 | Prefetched data returns |
| fill_addr_i | input | ADDR_W | Address of the returned data |
| fill_data_i | input | DATA_W | Returned data word |
| lk_valid_i | input | 1 | Demand lookup in the buffer |
| lk_addr_i | input | ADDR_W | Lookup address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_data_o | output | DATA_W | Data for a hit |

## Verification
A corrupted stride, confidence count or tag in the table shows up one edge after the next access by that PC. It appears as a request that is missing, early or at the wrong address, or as a request from a PC that should still be retraining. Damaged buffer state shows up at once, in the same cycle as the next lookup of an affected address: a wrong hit, a stale data word, or a second hit on a slot that should already be consumed. A faulty rotating pointer shows only after the buffer wraps, when the wrong older address goes missing. For that reason the bench compares every output, every cycle, against a behavioural model, including long random runs that wrap the buffer many times.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int CONF_W = 2;
  typedef logic [CONF_W-1:0] conf_t;
  localparam conf_t CONF_MAX  = conf_t'(3);
  localparam conf_t CONF_FIRE = conf_t'(2);

  function automatic conf_t conf_up(conf_t c);
    return (c == CONF_MAX) ? c : c + conf_t'(1);
  endfunction
endpackage

// File: rtl/pf_stride_table.sv
module pf_stride_table import pf_pkg::*; #(
  parameter int PC_W   = 16,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int DIST   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              obs_valid_i,
  input  logic [PC_W-1:0]   obs_pc_i,
  input  logic [ADDR_W-1:0] obs_addr_i,
  output logic              cand_valid_o,
  output logic [ADDR_W-1:0] cand_addr_o
);
  localparam int TAG_W   = PC_W - IDX_W;
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0]  last_q   [ENTRIES];
  logic [ADDR_W-1:0]  stride_q [ENTRIES];
  conf_t              conf_q   [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit, same;
  logic [ADDR_W-1:0] delta, n_stride;
  conf_t             n_conf;

  assign idx   = obs_pc_i[IDX_W-1:0];
  assign tag   = obs_pc_i[PC_W-1:IDX_W];
  assign hit   = vld_q[idx] && (tag_q[idx] == tag);
  assign delta = obs_addr_i - last_q[idx];
  assign same  = hit && (delta == stride_q[idx]);

  always_comb begin
    n_conf   = '0;
    n_stride = '0;
    if (hit) begin
      if (same) begin
        n_conf   = conf_up(conf_q[idx]);
        n_stride = stride_q[idx];
      end else if (conf_q[idx] == '0) begin
        n_stride = delta;           // retrain on the new delta
      end else begin
        n_conf   = conf_q[idx] - conf_t'(1);
        n_stride = stride_q[idx];
      end
    end
  end

  assign cand_valid_o = obs_valid_i && same && (delta != '0) && (n_conf >= CONF_FIRE);
  assign cand_addr_o  = obs_addr_i + ADDR_W'(DIST) * delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) conf_q[i] <= '0;
    end else if (obs_valid_i) begin
      vld_q[idx]  <= 1'b1;
      conf_q[idx] <= n_conf;
    end
  end

  always_ff @(posedge clk_i) begin
    if (obs_valid_i) begin
      tag_q[idx]    <= tag;
      last_q[idx]   <= obs_addr_i;
      stride_q[idx] <= n_stride;
    end
  end
endmodule

// File: rtl/pf_buffer.sv
module pf_buffer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic              probe_hit_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0]  vld_q;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q;

  logic [DEPTH-1:0] lk_m, fill_m, probe_m;
  logic [PTR_W-1:0] lk_sel, fill_sel;
  logic             fill_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign lk_m[g]    = vld_q[g] && (addr_q[g] == lk_addr_i);
    assign fill_m[g]  = vld_q[g] && (addr_q[g] == fill_addr_i);
    assign probe_m[g] = vld_q[g] && (addr_q[g] == probe_addr_i);
  end

  always_comb begin
    lk_sel   = '0;
    fill_sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (lk_m[i])   lk_sel   = PTR_W'(i);
      if (fill_m[i]) fill_sel = PTR_W'(i);
    end
  end

  assign fill_hit    = |fill_m;
  assign lk_hit_o    = lk_valid_i && (|lk_m);
  assign lk_data_o   = data_q[lk_sel];
  assign probe_hit_o = |probe_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      wptr_q <= '0;
    end else begin
      if (lk_hit_o) vld_q[lk_sel] <= 1'b0;
      // fill comes after the consume so a same-cycle fill stays resident
      if (fill_valid_i) begin
        if (fill_hit) begin
          vld_q[fill_sel] <= 1'b1;
        end else begin
          vld_q[wptr_q] <= 1'b1;
          wptr_q        <= (wptr_q == LAST) ? '0 : wptr_q + PTR_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_valid_i) begin
      if (fill_hit) begin
        data_q[fill_sel] <= fill_data_i;
      end else begin
        addr_q[wptr_q] <= fill_addr_i;
        data_q[wptr_q] <= fill_data_i;
      end
    end
  end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int PC_W      = 16,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 4,
  parameter int DIST      = 4,
  parameter int BUF_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              obs_valid_i,
  input  logic [PC_W-1:0]   obs_pc_i,
  input  logic [ADDR_W-1:0] obs_addr_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              req_ready_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o
);
  logic              cand_valid;
  logic [ADDR_W-1:0] cand_addr;
  logic              in_buf, dup, slot_free, load;
  logic              req_valid_q;
  logic [ADDR_W-1:0] req_addr_q;

  pf_stride_table #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DIST(DIST)
  ) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .obs_valid_i  (obs_valid_i),
    .obs_pc_i     (obs_pc_i),
    .obs_addr_i   (obs_addr_i),
    .cand_valid_o (cand_valid),
    .cand_addr_o  (cand_addr)
  );

  pf_buffer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(BUF_DEPTH)
  ) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_valid_i (fill_valid_i),
    .fill_addr_i  (fill_addr_i),
    .fill_data_i  (fill_data_i),
    .lk_valid_i   (lk_valid_i),
    .lk_addr_i    (lk_addr_i),
    .lk_hit_o     (lk_hit_o),
    .lk_data_o    (lk_data_o),
    .probe_addr_i (cand_addr),
    .probe_hit_o  (in_buf)
  );

  assign dup       = in_buf || (req_valid_q && (req_addr_q == cand_addr));
  assign slot_free = !req_valid_q || req_ready_i;
  assign load      = cand_valid && !dup && slot_free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_q <= 1'b0;
      req_addr_q  <= '0;
    end else if (load) begin
      req_valid_q <= 1'b1;
      req_addr_q  <= cand_addr;
    end else if (req_ready_i) begin
      req_valid_q <= 1'b0;
    end
  end

  assign req_valid_o = req_valid_q;
  assign req_addr_o  = req_addr_q;
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              obs_valid_i,
  input logic              req_valid_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              req_ready_i,
  input logic              fill_valid_i,
  input logic [ADDR_W-1:0] fill_addr_i,
  input logic [DATA_W-1:0] fill_data_i,
  input logic              lk_valid_i,
  input logic [ADDR_W-1:0] lk_addr_i,
  input logic              lk_hit_o,
  input logic [DATA_W-1:0] lk_data_o
);
  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

  p_req_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(obs_valid_i));

  p_req_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !obs_valid_i && !req_valid_o |=> !req_valid_o);

  p_lk_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !lk_hit_o);

  p_consume_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && lk_hit_o && !(fill_valid_i && fill_addr_i == lk_addr_i)
    |=> !(lk_valid_i && lk_hit_o && lk_addr_i == $past(lk_addr_i)));

  p_fill_resident_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |=> (!(lk_valid_i && lk_addr_i == $past(fill_addr_i)) ||
                      (lk_hit_o && lk_data_o == $past(fill_data_i))));
endmodule

bind stride_prefetcher pf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .obs_valid_i  (obs_valid_i),
  .req_valid_o  (req_valid_o),
  .req_addr_o   (req_addr_o),
  .req_ready_i  (req_ready_i),
  .fill_valid_i (fill_valid_i),
  .fill_addr_i  (fill_addr_i),
  .fill_data_i  (fill_data_i),
  .lk_valid_i   (lk_valid_i),
  .lk_addr_i    (lk_addr_i),
  .lk_hit_o     (lk_hit_o),
  .lk_data_o    (lk_data_o)
);

// File: tb/sim_stride_prefetcher.sv
`timescale 1ns/1ps
module sim_stride_prefetcher;
  localparam int PC_W = 16, AW = 32, DW = 32, IW = 4, DIST = 4, DEPTH = 4;
  localparam int NENT = 1 << IW;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic            obs_v = 0, rdy = 1, f_v = 0, l_v = 0;
  logic [PC_W-1:0] obs_pc = '0;
  logic [AW-1:0]   obs_a = '0, f_a = '0, l_a = '0;
  logic [DW-1:0]   f_d = '0;
  logic            req_valid_o, lk_hit_o;
  logic [AW-1:0]   req_addr_o;
  logic [DW-1:0]   lk_data_o;

  stride_prefetcher #(.PC_W(PC_W), .ADDR_W(AW), .DATA_W(DW), .IDX_W(IW),
                      .DIST(DIST), .BUF_DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .obs_valid_i(obs_v), .obs_pc_i(obs_pc), .obs_addr_i(obs_a),
    .req_valid_o(req_valid_o), .req_addr_o(req_addr_o), .req_ready_i(rdy),
    .fill_valid_i(f_v), .fill_addr_i(f_a), .fill_data_i(f_d),
    .lk_valid_i(l_v), .lk_addr_i(l_a), .lk_hit_o(lk_hit_o), .lk_data_o(lk_data_o));

  int unsigned n_chk = 0, n_err = 0;
  string cur = "R1";
  bit done = 0;

  // behavioural reference
  bit            t_v [NENT];
  logic [11:0]   t_tag [NENT];
  logic [AW-1:0] t_last [NENT], t_str [NENT];
  int            t_conf [NENT];
  bit            b_v [DEPTH];
  logic [AW-1:0] b_a [DEPTH];
  logic [DW-1:0] b_d [DEPTH];
  int            b_wp;
  bit            m_rv;
  logic [AW-1:0] m_ra;
  logic [AW-1:0] acc_q[$], fil_q[$];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic int buf_find(logic [AW-1:0] a);
    for (int i = 0; i < DEPTH; i++) if (b_v[i] && b_a[i] == a) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NENT; i++) begin t_v[i] = 0; t_conf[i] = 0; end
    for (int i = 0; i < DEPTH; i++) b_v[i] = 0;
    b_wp = 0; m_rv = 0; m_ra = '0;
  endtask

  task automatic model_step();
    int idx, ls, fs, nc;
    bit hit, same, cand, dup;
    logic [AW-1:0] dl, ca;
    idx = int'(obs_pc[IW-1:0]);
    hit = t_v[idx] && t_tag[idx] == obs_pc[PC_W-1:IW];
    dl = obs_a - t_last[idx];
    same = hit && dl == t_str[idx];
    nc = !hit ? 0 : same ? (t_conf[idx] == 3 ? 3 : t_conf[idx] + 1)
                         : (t_conf[idx] == 0 ? 0 : t_conf[idx] - 1);
    ca = obs_a + DIST * dl;
    cand = obs_v && same && dl != 0 && nc >= 2;
    dup = buf_find(ca) >= 0 || (m_rv && m_ra == ca);
    if (m_rv && rdy) acc_q.push_back(m_ra);
    if (cand && !dup && (!m_rv || rdy)) begin m_rv = 1; m_ra = ca; end
    else if (rdy) m_rv = 0;
    if (obs_v) begin
      if (!hit) t_str[idx] = '0;
      else if (!same && t_conf[idx] == 0) t_str[idx] = dl;
      t_v[idx] = 1; t_tag[idx] = obs_pc[PC_W-1:IW]; t_last[idx] = obs_a; t_conf[idx] = nc;
    end
    ls = l_v ? buf_find(l_a) : -1;
    fs = buf_find(f_a);
    if (ls >= 0) b_v[ls] = 0;
    if (f_v) begin
      fil_q.push_back(f_a);
      if (fs >= 0) begin b_v[fs] = 1; b_d[fs] = f_d; end
      else begin
        b_v[b_wp] = 1; b_a[b_wp] = f_a; b_d[b_wp] = f_d;
        b_wp = (b_wp + 1) % DEPTH;
      end
    end
  endtask

  task automatic compare();
    int s;
    s = l_v ? buf_find(l_a) : -1;
    chk(req_valid_o == m_rv, {cur, " req_valid"}, 64'(req_valid_o), 64'(m_rv));
    if (m_rv) chk(req_addr_o == m_ra, {cur, " req_addr"}, 64'(req_addr_o), 64'(m_ra));
    chk(lk_hit_o == (s >= 0), {cur, " lk_hit"}, 64'(lk_hit_o), 64'(s >= 0));
    if (s >= 0) chk(lk_data_o == b_d[s], {cur, " lk_data"}, 64'(lk_data_o), 64'(b_d[s]));
  endtask

  // inputs change at negedge, outputs checked mid-low-phase, model advances at posedge
  task automatic tick();
    #5 compare();
    @(posedge clk);
    if (rst_ni) model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    obs_v = 0; f_v = 0; l_v = 0;
  endtask

  task automatic obs(logic [PC_W-1:0] pc, logic [AW-1:0] a);
    idle(); obs_v = 1; obs_pc = pc; obs_a = a; tick();
  endtask

  task automatic fill(logic [AW-1:0] a, logic [DW-1:0] d);
    idle(); f_v = 1; f_a = a; f_d = d; tick();
  endtask

  // check a lookup combinationally, then consume it at the edge
  task automatic look(logic [AW-1:0] a, bit exp_hit, logic [DW-1:0] exp_d, string tag);
    idle(); l_v = 1; l_a = a; #1;
    chk(lk_hit_o == exp_hit, tag, 64'(lk_hit_o), 64'(exp_hit));
    if (exp_hit) chk(lk_data_o == exp_d, tag, 64'(lk_data_o), 64'(exp_d));
    #1 tick();
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    // R1: reset state
    cur = "R1";
    l_v = 1; l_a = 32'h0;
    tick(); tick();
    rst_ni = 1;
    tick();
    chk(req_valid_o == 0, "R1 req after reset", 64'(req_valid_o), 0);
    idle();

    // R3: positive stride, first request after the fourth access
    cur = "R3"; rdy = 1;
    obs(16'h0040, 32'h1000); obs(16'h0040, 32'h1010); obs(16'h0040, 32'h1020);
    chk(req_valid_o == 0, "R3 no early req", 64'(req_valid_o), 0);
    obs(16'h0040, 32'h1030);
    chk(req_valid_o && req_addr_o == 32'h1070, "R3 first req", 64'(req_addr_o), 64'h1070);
    idle(); tick();
    // R3: negative stride wraps
    obs(16'h0051, 32'h5000); obs(16'h0051, 32'h4FF8); obs(16'h0051, 32'h4FF0);
    obs(16'h0051, 32'h4FE8);
    chk(req_valid_o && req_addr_o == 32'h4FC8, "R3 neg stride", 64'(req_addr_o), 64'h4FC8);
    idle(); tick();

    // R5: zero stride
    cur = "R5";
    for (int i = 0; i < 6; i++) begin
      obs(16'h0062, 32'h3000);
      chk(req_valid_o == 0, "R5 zero stride", 64'(req_valid_o), 0);
    end

    // R8 / R9: buffer consume, rotation, in-place update
    cur = "R8";
    fill(32'h1070, 32'hAAAA0001);
    look(32'h1070, 1, 32'hAAAA0001, "R8 hit");
    look(32'h1070, 0, 0, "R8 consumed");
    cur = "R9";
    fill(32'hA0, 32'h11); fill(32'hB0, 32'h22); fill(32'hC0, 32'h33);
    fill(32'hD0, 32'h44); fill(32'hE0, 32'h55);
    look(32'hA0, 0, 0, "R9 oldest replaced");
    look(32'hE0, 1, 32'h55, "R9 newest");
    fill(32'hD0, 32'h99);
    look(32'hD0, 1, 32'h99, "R9 in place");

    // R10: lookup disabled
    cur = "R10";
    fill(32'h7700, 32'h77);
    idle(); l_a = 32'h7700; #1;
    chk(lk_hit_o == 0, "R10 gated", 64'(lk_hit_o), 0);
    #1 tick();
    look(32'h7700, 1, 32'h77, "R10 entry untouched");

    // R6: hold under back-pressure, drop while full
    cur = "R6"; rdy = 0;
    obs(16'h0073, 32'h8000); obs(16'h0073, 32'h8004); obs(16'h0073, 32'h8008);
    obs(16'h0073, 32'h800C);
    chk(req_addr_o == 32'h801C, "R6 req", 64'(req_addr_o), 64'h801C);
    obs(16'h0073, 32'h8010);
    chk(req_valid_o && req_addr_o == 32'h801C, "R6 held", 64'(req_addr_o), 64'h801C);
    rdy = 1; idle(); tick();
    chk(req_valid_o == 0, "R6 cleared", 64'(req_valid_o), 0);

    // R7: candidate already buffered
    cur = "R7";
    fill(32'h8024, 32'h5A);
    obs(16'h0073, 32'h8014);
    chk(req_valid_o == 0, "R7 dup suppressed", 64'(req_valid_o), 0);

    // R4: one mismatch, then recovery
    cur = "R4";
    obs(16'h0073, 32'h8030);
    chk(req_valid_o == 0, "R4 mismatch no req", 64'(req_valid_o), 0);
    obs(16'h0073, 32'h8034);
    chk(req_valid_o && req_addr_o == 32'h8044, "R4 resumes", 64'(req_addr_o), 64'h8044);

    // R2: alias at the same index evicts, owner must retrain
    cur = "R2";
    obs(16'h0083, 32'h9000);
    obs(16'h0073, 32'h8038); obs(16'h0073, 32'h803C); obs(16'h0073, 32'h8040);
    chk(req_valid_o == 0, "R2 retraining", 64'(req_valid_o), 0);
    obs(16'h0073, 32'h8044);
    chk(req_valid_o && req_addr_o == 32'h8054, "R2 retrained", 64'(req_addr_o), 64'h8054);

    // random traffic against the model (R3 R4 R6 R7 R8 R9)
    cur = "RND";
    begin
      logic [AW-1:0] pa [4];
      logic [AW-1:0] ps [4];
      for (int p = 0; p < 4; p++) begin pa[p] = 32'h10000 * (p + 1); ps[p] = 32'(4 << p); end
      ps[3] = -32'd8;
      for (int c = 0; c < 4000; c++) begin
        int p;
        idle();
        rdy = ($urandom % 3) != 0;
        if ($urandom % 2) begin
          p = $urandom % 4;
          pa[p] = pa[p] + (($urandom % 8) == 0 ? ps[p] * 3 : ps[p]);
          obs_v = 1; obs_pc = 16'(16'h0100 * (p + 1) + p); obs_a = pa[p];
        end
        if (acc_q.size() > 0 && ($urandom % 2)) begin
          f_v = 1; f_a = acc_q.pop_front(); f_d = $urandom;
        end
        if (fil_q.size() > 0 && ($urandom % 2)) begin
          l_v = 1; l_a = fil_q[$urandom % fil_q.size()];
          if (fil_q.size() > 16) void'(fil_q.pop_front());
        end
        tick();
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule